// File: doc/BRIEF.md
# BCD Stopwatch Counter with Lap Capture

This block is a decimal stopwatch for the sub-second range. It takes a one-cycle 1 kHz tick strobe and counts it into three BCD digits: thousandths, hundredths and tenths of a second. A small register interface gives software control over clocking, run/stop and clearing. Software can read the live digits, read four event flags and mask them, and read two lap status bits. Events are a 10 Hz wrap, a 1 Hz wrap and the two direct-button events.

Two asynchronous button pins can drive the stopwatch directly once enabled. One pin toggles run/stop and the other freezes a lap snapshot of the digits. A select bit swaps the roles of the two pins. While direct mode is on, digit reads return the frozen lap value, so software sees a stable lap time while counting continues. Status bits report when a lap snapshot was overwritten before it was read, and when the counter rolled over the tenths digit after the snapshot was taken.

Top module: `swatch_bcd_top`

## Requirements
- R1: The digits are read at address 5 (thousandths), 6 (hundredths) and 7 (tenths), each 0 to 9 in BCD. All are 0 after reset, and while counting they hold the number of counted ticks modulo 1000.
- R2: The run bit (address 0, bit 1, read/write, 0 after reset) lets a tick advance the counter only when it is 1. When run is 0 the digits hold.
- R3: Writing address 0 with bit 2 set clears all digits on the next clock edge, even if a tick arrives in the same cycle. A write with bit 2 at 0 leaves the digits unchanged, and bit 2 always reads 0.
- R4: The clock-enable bit (address 0, bit 0, 0 after reset) freezes the counter while it is 0, whatever the run bit and the ticks do.
- R5: Address 1 holds the direct-enable bit (bit 0) and the swap bit (bit 1). Both pins pass through a two-flop synchronizer and are edge-detected. With swap at 0, pin A is run/stop and pin B is lap; with swap at 1 the roles are exchanged. A rising edge on the run/stop pin toggles the run bit. Pins have no effect while direct-enable is 0.
- R6: The flag register is at address 3: bit 0 is 10 Hz, bit 1 is 1 Hz, bit 2 is direct run and bit 3 is direct lap. Each flag sets on its event and clears when a 1 is written to its bit; writing 0 leaves it unchanged.
- R7: The 10 Hz event occurs when the hundredths digit wraps from 9 to 0. The 1 Hz event occurs when the tenths digit wraps from 9 to 0.
- R8: The mask register (address 4, same bit positions as the flags, 0 after reset) enables each flag. The irq output is 1 exactly when some flag and its mask bit are both 1.
- R9: A lap edge copies the live digits into the lap register. While direct-enable is 1, digit reads return the lap register; otherwise they return the live digits.
- R10: The renewal status bit (address 2, bit 0) sets when a lap capture occurs while the previous capture is still unread. A digit read (rdEn high) while direct-enable is 1 marks the capture as read and clears both status bits.
- R11: The carry-up status bit (address 2, bit 1) sets when the tenths digit wraps while the current capture is unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | 1 kHz count strobe, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (marks a lap read) |
| addr | input | 3 | Register address |
| wrData | input | 4 | Write data |
| rdData | output | 4 | Read data for addr, combinational |
| pinA | input | 1 | Direct button A, asynchronous |
| pinB | input | 1 | Direct button B, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps a full second of ticks and compares every digit after every tick. A carry chain that skips or double-steps a digit, or that wraps at the wrong value, fails at the first bad count. The 10 Hz and 1 Hz flags are checked one tick before and exactly at the 100th and 1000th tick, which catches an event tied to the wrong digit or fired a tick early. A clear written in the same cycle as a tick must leave zero, which exposes a reversed priority. The lap tests capture a known count, keep counting, and expect the frozen value back. They also drive a double capture and a roll-over after a capture, to expose renewal or carry-up flags that never set or never clear. Swapped and disabled pin roles are checked through the run bit and the flags, so a design that ignores the swap or the enable toggles the wrong function.

// File: rtl/swatch_pkg.sv
package swatch_pkg;
  localparam int REG_W = 4;
  localparam int DIG_W = 4;

  localparam int CTRL_CLKEN = 0;
  localparam int CTRL_RUN   = 1;
  localparam int CTRL_CLR   = 2;
  localparam int DIR_EN     = 0;
  localparam int DIR_SWAP   = 1;
  localparam int ST_RENEW   = 0;
  localparam int ST_CARRY   = 1;
  localparam int FLG_10HZ   = 0;
  localparam int FLG_1HZ    = 1;
  localparam int FLG_RUN    = 2;
  localparam int FLG_LAP    = 3;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_DIR   = 1;
  localparam int ADDR_STAT  = 2;
  localparam int ADDR_FLAG  = 3;
  localparam int ADDR_MASK  = 4;
  localparam int ADDR_DIG0  = 5;

  typedef struct packed {
    logic clear;
    logic advance;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/swatch_dp.sv
module swatch_dp
  import swatch_pkg::*;
#(
  parameter int NDIG = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             stb,
  output logic [NDIG*DIG_W-1:0] liveDigits,
  output logic [NDIG*DIG_W-1:0] capDigits,
  output logic                  wrapSub,
  output logic                  wrapTop
);
  localparam logic [DIG_W-1:0] DIG_MAX = DIG_W'(9);
  localparam logic [DIG_W-1:0] DIG_ONE = DIG_W'(1);

  logic [NDIG:0] carry;
  assign carry[0] = stb.advance & ~stb.clear;

  for (genvar i = 0; i < NDIG; i++) begin : gDigit
    logic [DIG_W-1:0] digQ;
    assign carry[i+1] = carry[i] & (digQ == DIG_MAX);
    assign liveDigits[i*DIG_W +: DIG_W] = digQ;

    always_ff @(posedge clk) begin
      if (!rstN || stb.clear) begin
        digQ <= '0;
      end else if (carry[i]) begin
        digQ <= (digQ == DIG_MAX) ? '0 : digQ + DIG_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capDigits <= '0;
    end else if (stb.capture) begin
      capDigits <= liveDigits;
    end
  end

  assign wrapSub = carry[NDIG-1];
  assign wrapTop = carry[NDIG];
endmodule

// File: rtl/swatch_ctrl.sv
module swatch_ctrl
  import swatch_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int AW = $clog2(ADDR_DIG0 + NDIG)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [AW-1:0]         addr,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  input  logic                  pinA,
  input  logic                  pinB,
  output logic                  irq,
  input  logic [NDIG*DIG_W-1:0] liveDigits,
  input  logic [NDIG*DIG_W-1:0] capDigits,
  input  logic                  wrapSub,
  input  logic                  wrapTop,
  output dpStrobe_t             stb
);
  logic clkEnQ, runQ, dirEnQ, swapQ;
  logic renewQ, carryQ, freshQ;
  logic [REG_W-1:0] flagQ, maskQ;
  logic [2:0] syncA, syncB;

  logic edgeA, edgeB, runEdge, lapEdge;
  logic wrCtrl, wrDir, wrFlag, wrMask, digitRead;
  logic [REG_W-1:0] events;
  logic [NDIG*DIG_W-1:0] shown;

  assign edgeA   = syncA[1] & ~syncA[2];
  assign edgeB   = syncB[1] & ~syncB[2];
  assign runEdge = dirEnQ & (swapQ ? edgeB : edgeA);
  assign lapEdge = dirEnQ & (swapQ ? edgeA : edgeB);

  assign wrCtrl = wrEn && (addr == AW'(ADDR_CTRL));
  assign wrDir  = wrEn && (addr == AW'(ADDR_DIR));
  assign wrFlag = wrEn && (addr == AW'(ADDR_FLAG));
  assign wrMask = wrEn && (addr == AW'(ADDR_MASK));
  assign digitRead = rdEn && dirEnQ && (addr >= AW'(ADDR_DIG0));

  assign stb.clear   = wrCtrl & wrData[CTRL_CLR];
  assign stb.advance = tick & clkEnQ & runQ;
  assign stb.capture = lapEdge;

  always_comb begin
    events = '0;
    events[FLG_10HZ] = wrapSub;
    events[FLG_1HZ]  = wrapTop;
    events[FLG_RUN]  = runEdge;
    events[FLG_LAP]  = lapEdge;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      clkEnQ <= 1'b0;
      runQ <= 1'b0;
      dirEnQ <= 1'b0;
      swapQ <= 1'b0;
      flagQ <= '0;
      maskQ <= '0;
      freshQ <= 1'b0;
      renewQ <= 1'b0;
      carryQ <= 1'b0;
    end else begin
      syncA <= {syncA[1:0], pinA};
      syncB <= {syncB[1:0], pinB};
      if (wrCtrl) begin
        clkEnQ <= wrData[CTRL_CLKEN];
        runQ <= wrData[CTRL_RUN];
      end else if (runEdge) begin
        runQ <= ~runQ;
      end
      if (wrDir) begin
        dirEnQ <= wrData[DIR_EN];
        swapQ <= wrData[DIR_SWAP];
      end
      if (wrMask) maskQ <= wrData;
      flagQ <= (flagQ & ~(wrFlag ? wrData : '0)) | events;
      if (lapEdge) freshQ <= 1'b1;
      else if (digitRead) freshQ <= 1'b0;
      if (lapEdge && freshQ) renewQ <= 1'b1;
      else if (digitRead) renewQ <= 1'b0;
      if (wrapTop && freshQ) carryQ <= 1'b1;
      else if (digitRead) carryQ <= 1'b0;
    end
  end

  assign shown = dirEnQ ? capDigits : liveDigits;

  always_comb begin
    rdData = '0;
    case (addr)
      AW'(ADDR_CTRL): begin
        rdData[CTRL_CLKEN] = clkEnQ;
        rdData[CTRL_RUN] = runQ;
      end
      AW'(ADDR_DIR): begin
        rdData[DIR_EN] = dirEnQ;
        rdData[DIR_SWAP] = swapQ;
      end
      AW'(ADDR_STAT): begin
        rdData[ST_RENEW] = renewQ;
        rdData[ST_CARRY] = carryQ;
      end
      AW'(ADDR_FLAG): rdData = flagQ;
      AW'(ADDR_MASK): rdData = maskQ;
      default: begin
        for (int i = 0; i < NDIG; i++) begin
          if (addr == AW'(ADDR_DIG0 + i)) rdData = shown[i*DIG_W +: DIG_W];
        end
      end
    endcase
  end

  assign irq = |(flagQ & maskQ);
endmodule

// File: rtl/swatch_bcd_top.sv
module swatch_bcd_top
  import swatch_pkg::*;
#(
  parameter int NDIG = 3,
  localparam int AW = $clog2(ADDR_DIG0 + NDIG)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AW-1:0]    addr,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             pinA,
  input  logic             pinB,
  output logic             irq
);
  dpStrobe_t stb;
  logic [NDIG*DIG_W-1:0] liveDigits, capDigits;
  logic wrapSub, wrapTop;

  swatch_ctrl #(.NDIG(NDIG)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pinA(pinA),
    .pinB(pinB), .irq(irq), .liveDigits(liveDigits),
    .capDigits(capDigits), .wrapSub(wrapSub), .wrapTop(wrapTop),
    .stb(stb)
  );

  swatch_dp #(.NDIG(NDIG)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .liveDigits(liveDigits),
    .capDigits(capDigits), .wrapSub(wrapSub), .wrapTop(wrapTop)
  );
endmodule

// File: rtl/swatch_chk.sv
module swatch_chk
  import swatch_pkg::*;
#(
  parameter int NDIG = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input dpStrobe_t             stb,
  input logic [NDIG*DIG_W-1:0] liveDigits,
  input logic [NDIG*DIG_W-1:0] capDigits
);
  localparam logic [DIG_W-1:0] DIG_MAX = DIG_W'(9);
  localparam logic [DIG_W-1:0] DIG_ONE = DIG_W'(1);

  for (genvar i = 0; i < NDIG; i++) begin : gBcd
    AST_DIGIT_BCD: assert property (@(posedge clk) disable iff (!rstN)
      liveDigits[i*DIG_W +: DIG_W] <= DIG_MAX); // R1
  end

  AST_LSD_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.clear && liveDigits[DIG_W-1:0] != DIG_MAX) |=>
    (liveDigits[DIG_W-1:0] == $past(liveDigits[DIG_W-1:0]) + DIG_ONE)); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.advance && !stb.clear) |=> $stable(liveDigits)); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (liveDigits == '0)); // R3

  AST_LAP_COPY: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |=> (capDigits == $past(liveDigits))); // R9
endmodule

bind swatch_bcd_top swatch_chk #(.NDIG(NDIG)) uChk (
  .clk(clk), .rstN(rstN), .stb(stb),
  .liveDigits(liveDigits), .capDigits(capDigits)
);

// File: tb/tb_swatch_bcd_top.sv
module tb_swatch_bcd_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, wrEn = 1'b0, rdEn = 1'b0, pinA = 1'b0, pinB = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wrData = '0;
  logic [3:0] rdData;
  logic irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  swatch_bcd_top dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pinA(pinA),
    .pinB(pinB), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d, input bit withTick = 0);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d; tick = withTick;
    @(negedge clk);
    wrEn = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [3:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse(input bit onA);
    @(negedge clk);
    if (onA) pinA = 1'b1; else pinB = 1'b1;
    repeat (3) @(negedge clk);
    pinA = 1'b0; pinB = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [3:0] e, input string req);
    logic [3:0] v;
    rd(a, v);
    chk(v == e, req, v, e);
  endtask

  task automatic expectCount(input int n, input string req);
    logic [3:0] d0, d1, d2;
    int got;
    rd(3'd5, d0); rd(3'd6, d1); rd(3'd7, d2);
    got = d2 * 100 + d1 * 10 + d0;
    chk(d0 == 4'(n % 10) && d1 == 4'((n / 10) % 10) && d2 == 4'((n / 100) % 10),
        req, got, n % 1000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state: R1, R2, R4, R6, R8
    for (int a = 0; a < 8; a++) expectReg(3'(a), 4'd0, "R1 reset regs");
    chk(irq == 1'b0, "R8 reset irq", irq, 0);

    // R4: clock enable off freezes even with run on
    wr(3'd0, 4'b0010);
    ticks(5);
    expectCount(0, "R4 gated hold");

    // R1/R7: full-second sweep with event flag boundaries
    wr(3'd0, 4'b0011);
    for (int k = 1; k <= 1000; k++) begin
      ticks(1);
      expectCount(k, "R1 sweep");
      if (k == 99)   expectReg(3'd3, 4'b0000, "R7 no 10Hz before wrap");
      if (k == 100)  expectReg(3'd3, 4'b0001, "R7 10Hz at hundredths wrap");
      if (k == 999)  expectReg(3'd3, 4'b0001, "R7 no 1Hz before wrap");
      if (k == 1000) expectReg(3'd3, 4'b0011, "R7 1Hz at tenths wrap");
    end

    // R6/R8: masks and write-1-to-clear
    chk(irq == 1'b0, "R8 masked irq", irq, 0);
    wr(3'd4, 4'b0001);
    chk(irq == 1'b1, "R8 enabled irq", irq, 1);
    wr(3'd3, 4'b0001);
    expectReg(3'd3, 4'b0010, "R6 clear one flag");
    chk(irq == 1'b0, "R8 irq drops", irq, 0);
    wr(3'd3, 4'b0000);
    expectReg(3'd3, 4'b0010, "R6 write zero no effect");
    wr(3'd4, 4'b0010);
    chk(irq == 1'b1, "R8 irq 1Hz", irq, 1);
    wr(3'd3, 4'b0010);
    expectReg(3'd3, 4'b0000, "R6 flags clear");
    chk(irq == 1'b0, "R8 irq low", irq, 0);
    wr(3'd4, 4'b0000);

    // R2: stopped counter holds
    wr(3'd0, 4'b0001);
    ticks(7);
    expectCount(0, "R2 stopped hold");

    // R3: clear strobe
    wr(3'd0, 4'b0011);
    ticks(37);
    expectCount(37, "R2 run resumes");
    wr(3'd0, 4'b0011);
    expectCount(37, "R3 clear bit zero no effect");
    wr(3'd0, 4'b0111, 1'b1);
    expectCount(0, "R3 clear wins over tick");
    expectReg(3'd0, 4'b0011, "R3 clear bit reads zero");

    // R5: direct run pin toggles run
    wr(3'd1, 4'b0001);
    pulse(1'b1);
    expectReg(3'd0, 4'b0001, "R5 pin A stops");
    expectReg(3'd3, 4'b0100, "R6 run flag");
    wr(3'd3, 4'b1111);
    pulse(1'b1);
    expectReg(3'd0, 4'b0011, "R5 pin A restarts");

    // R9: lap capture and frozen read
    wr(3'd0, 4'b0111);
    ticks(25);
    pulse(1'b0);
    expectReg(3'd3, 4'b1100, "R6 lap flag");
    ticks(10);
    expectCount(25, "R9 lap frozen");
    expectReg(3'd2, 4'b0000, "R10 no renewal on single lap");
    wr(3'd1, 4'b0000);
    expectCount(35, "R9 live when direct off");
    wr(3'd1, 4'b0001);

    // R10: renewal on double capture, cleared by read
    pulse(1'b0);
    pulse(1'b0);
    expectReg(3'd2, 4'b0001, "R10 renewal set");
    expectReg(3'd5, 4'd5, "R10 lap read");
    expectReg(3'd2, 4'b0000, "R10 renewal cleared");

    // R11: carry-up after capture
    pulse(1'b0);
    ticks(965);
    expectReg(3'd2, 4'b0010, "R11 carry-up set");
    expectReg(3'd7, 4'd0, "R11 lap tenths");
    expectReg(3'd2, 4'b0000, "R11 carry-up cleared");
    expectCount(35, "R9 lap still held");

    // R5: swapped roles
    wr(3'd3, 4'b1111);
    wr(3'd1, 4'b0011);
    pulse(1'b0);
    expectReg(3'd0, 4'b0001, "R5 swapped pin B stops");
    expectReg(3'd3, 4'b0100, "R5 swapped run flag");
    wr(3'd3, 4'b1111);
    wr(3'd4, 4'b1000);
    pulse(1'b1);
    expectReg(3'd3, 4'b1000, "R5 swapped pin A laps");
    chk(irq == 1'b1, "R8 lap irq", irq, 1);
    expectCount(0, "R9 swapped lap value");

    // R5: disabled pins ignored
    wr(3'd1, 4'b0000);
    wr(3'd3, 4'b1111);
    chk(irq == 1'b0, "R8 irq cleared", irq, 0);
    pulse(1'b1);
    pulse(1'b0);
    expectReg(3'd0, 4'b0001, "R5 disabled no toggle");
    expectReg(3'd3, 4'b0000, "R5 disabled no flags");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule